// File: doc/BRIEF.md
# Step Attenuator Parallel Programming Sequencer

This block sits on the host side of a five-bit, parallel-controlled RF step attenuator. It accepts a requested attenuation code over a valid/ready handshake. It then drives the five control lines and the latch-enable line so that the attenuator's timing limits on the strobe are met. The code is the attenuation in 0.5 dB units, from 0 (the 0 dB reference) to 31 (15.5 dB).

Each request chooses one of two modes. In latched mode the word is placed on the control lines while latch-enable is low, and a timed high pulse captures it. In transparent mode latch-enable is left high, so the control lines act at once. Switching between the modes follows a fixed order that never exposes a half-formed word. The setup, pulse and hold times and the minimum spacing between updates are given in nanoseconds. They are turned into clock counts from a clock-frequency parameter.

A static output selects the attenuator's power-up default. A status output reports the code the device currently holds.

Top module: `atten_prog_seq`

## Requirements
- R1: `ctl_bits[4]` carries the 8 dB weight, then 4, 2 and 1 dB down to `ctl_bits[0]` at 0.5 dB. Once a request's sequence completes, `ctl_bits` and `committed_code` both equal the requested code, for every code from 0 to 31.
- R2: During and after reset the outputs hold `le` = 0, `ctl_bits` = 0 and `req_ready` = 1. `pup_sel` equals the PUP_SEL parameter. `committed_code` holds the power-up default: 16 (8 dB) when PUP_SEL is 1, and 0 otherwise. These values stay until the first request is accepted.
- R3: A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` then stays low until the sequence and the update interval have both elapsed. A request presented while `req_ready` is low leaves `ctl_bits` and `le` untouched.
- R4: In latched mode `ctl_bits` changes only while `le` is low. The word is stable for at least SETUP_CYC cycles before `le` rises.
- R5: The latch pulse keeps `le` high for at least PULSE_CYC cycles.
- R6: After `le` falls, `ctl_bits` stays unchanged for at least HOLD_CYC cycles.
- R7: In latched mode `committed_code` takes the new code in the same cycle that `le` falls. It keeps its old value while the pulse is high.
- R8: In transparent mode with `le` already high, the new word appears on `ctl_bits`, and `committed_code` follows it in the same cycle without any strobe.
- R9: On a change from latched to transparent mode, the new word is driven first and held stable for SETUP_CYC cycles before `le` rises. The word counts as committed from that rise.
- R10: On a change from transparent to latched mode, `le` falls first. `ctl_bits` keeps the old word in that cycle and for HOLD_CYC cycles after it.
- R11: Two successive commits are at least UPDATE_CYC cycles apart.
- R12: Each cycle count is max(1, ceil(limit_ns × CLK_HZ / 1e9)). At 125 MHz this gives setup 2, pulse exactly 4, hold 2 and update interval 125 cycles. The latch pulse lasts exactly PULSE_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_code | input | 5 | Requested attenuation in 0.5 dB units |
| req_direct | input | 1 | 1 = transparent mode, 0 = latched mode |
| ctl_bits | output | 5 | Attenuator control word (bit 4 = 8 dB) |
| le | output | 1 | Latch-enable line |
| pup_sel | output | 1 | Static power-up default select |
| committed_code | output | 5 | Code currently held by the attenuator |

## Verification
Latched requests run through the five single-bit weights, all ones and all zeros. This shows that the bit ordering is right and that the commit happens on the falling edge of the strobe rather than the rising edge. Mixed sequences cover four transitions: latched to transparent, transparent to transparent (including a repeated code), transparent back to latched, and a repeat of a latched code. These separate the two mode-change orders from each other and from a plain update. A request held on the inputs while the sequencer is busy shows whether the busy interval is respected. The setup, pulse, hold and spacing windows are measured on every strobe, so any early or late edge is caught.

// File: rtl/atten_seq_pkg.sv
`timescale 1ns/1ps
package atten_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DROP,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_GAP
    } seq_state_e;

    // Cycles covering a nanosecond limit, rounded up, never below one.
    function automatic int unsigned ns_to_cycles(input longint unsigned ns,
                                                 input longint unsigned hz);
        longint unsigned c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/atten_cycle_timer.sv
`timescale 1ns/1ps
module atten_cycle_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/atten_commit_reg.sv
`timescale 1ns/1ps
module atten_commit_reg #(
    parameter int unsigned CODE_W   = 5,
    parameter int unsigned RST_CODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_en,
    input  logic [CODE_W-1:0] commit_val,
    output logic [CODE_W-1:0] code_q
);
    logic [CODE_W-1:0] code_d;

    always_comb begin
        code_d = code_q;
        if (commit_en) code_d = commit_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= CODE_W'(RST_CODE);
        else        code_q <= code_d;
    end
endmodule

// File: rtl/atten_prog_seq.sv
`timescale 1ns/1ps
module atten_prog_seq
    import atten_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 125_000_000,
    parameter int unsigned SETUP_NS  = 10,
    parameter int unsigned PULSE_NS  = 30,
    parameter int unsigned HOLD_NS   = 10,
    parameter int unsigned UPDATE_NS = 1000,
    parameter int unsigned CODE_W    = 5,
    parameter bit          PUP_SEL   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CODE_W-1:0] req_code,
    input  logic              req_direct,
    output logic [CODE_W-1:0] ctl_bits,
    output logic              le,
    output logic              pup_sel,
    output logic [CODE_W-1:0] committed_code
);
    localparam int unsigned SETUP_CYC  = ns_to_cycles(SETUP_NS, CLK_HZ);
    localparam int unsigned PULSE_CYC  = ns_to_cycles(PULSE_NS, CLK_HZ);
    localparam int unsigned HOLD_CYC   = ns_to_cycles(HOLD_NS, CLK_HZ);
    localparam int unsigned UPDATE_CYC = ns_to_cycles(UPDATE_NS, CLK_HZ);
    localparam int unsigned CNT_MAX    = max2(max2(SETUP_CYC, PULSE_CYC),
                                              max2(HOLD_CYC, UPDATE_CYC));
    localparam int unsigned CNT_W      = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LD  = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] UPDATE_LD = CNT_W'(UPDATE_CYC - 1);
    localparam int unsigned PUP_CODE = PUP_SEL ? (1 << (CODE_W - 1)) : 0;

    typedef struct packed {
        seq_state_e        st;
        logic [CODE_W-1:0] bits;
        logic              le;
        logic [CODE_W-1:0] pend;
        logic              pend_dir;
    } seq_regs_t;

    localparam seq_regs_t REGS_RST = '{st: ST_IDLE, bits: '0, le: 1'b0,
                                       pend: '0, pend_dir: 1'b0};

    seq_regs_t         r_d, r_q;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic              commit_en;
    logic [CODE_W-1:0] commit_val;

    atten_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    atten_commit_reg #(.CODE_W(CODE_W), .RST_CODE(PUP_CODE)) u_commit (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_en  (commit_en),
        .commit_val (commit_val),
        .code_q     (committed_code)
    );

    always_comb begin
        r_d        = r_q;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        commit_en  = 1'b0;
        commit_val = r_q.bits;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.pend     = req_code;
                    r_d.pend_dir = req_direct;
                    if (req_direct && r_q.le) begin
                        // already transparent: word acts at once
                        r_d.bits   = req_code;
                        commit_en  = 1'b1;
                        commit_val = req_code;
                        r_d.st     = ST_GAP;
                        tmr_load   = 1'b1;
                        tmr_val    = UPDATE_LD;
                    end else if (!req_direct && r_q.le) begin
                        // leave transparent mode: lower the strobe first
                        r_d.le   = 1'b0;
                        r_d.st   = ST_DROP;
                        tmr_load = 1'b1;
                        tmr_val  = HOLD_LD;
                    end else begin
                        r_d.bits = req_code;
                        r_d.st   = ST_SETUP;
                        tmr_load = 1'b1;
                        tmr_val  = SETUP_LD;
                    end
                end
            end
            ST_DROP: begin
                if (tmr_expired) begin
                    r_d.bits = r_q.pend;
                    r_d.st   = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = SETUP_LD;
                end
            end
            ST_SETUP: begin
                if (tmr_expired) begin
                    r_d.le   = 1'b1;
                    tmr_load = 1'b1;
                    if (r_q.pend_dir) begin
                        commit_en = 1'b1;
                        r_d.st    = ST_GAP;
                        tmr_val   = UPDATE_LD;
                    end else begin
                        r_d.st  = ST_PULSE;
                        tmr_val = PULSE_LD;
                    end
                end
            end
            ST_PULSE: begin
                if (tmr_expired) begin
                    r_d.le    = 1'b0;
                    commit_en = 1'b1;
                    r_d.st    = ST_HOLD;
                    tmr_load  = 1'b1;
                    tmr_val   = HOLD_LD;
                end
            end
            ST_HOLD: begin
                if (tmr_expired) begin
                    r_d.st   = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = UPDATE_LD;
                end
            end
            ST_GAP: begin
                if (tmr_expired) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign ctl_bits  = r_q.bits;
    assign le        = r_q.le;
    assign pup_sel   = PUP_SEL;
endmodule

// File: rtl/atten_prog_seq_chk.sv
`timescale 1ns/1ps
module atten_prog_seq_chk #(
    parameter int unsigned CODE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [CODE_W-1:0] ctl_bits,
    input logic              le,
    input logic [CODE_W-1:0] committed_code
);
    // R10
    le_fall_bits_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(le) |-> $stable(ctl_bits));

    // R9
    le_rise_bits_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(le) |-> $stable(ctl_bits));

    // R3
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R7
    commit_moment_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(committed_code) |-> (le || $fell(le)));

    // R8
    direct_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (le && $past(le) && !$stable(ctl_bits)) |-> (committed_code == ctl_bits));

    // R1
    commit_matches_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(committed_code) |-> (committed_code == ctl_bits));
endmodule

bind atten_prog_seq atten_prog_seq_chk u_chk (.*);

// File: tb/sim_atten_prog_seq.sv
`timescale 1ns/1ps
module sim_atten_prog_seq;
    function automatic int bench_cycles(input int ns);
        int c;
        c = (ns * 125 + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int SETUP_C = bench_cycles(10);
    localparam int PULSE_C = bench_cycles(30);
    localparam int HOLD_C  = bench_cycles(10);
    localparam int UPD_C   = bench_cycles(1000);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [4:0] req_code = '0;
    logic       req_direct = 1'b0;
    logic [4:0] ctl_bits;
    logic       le;
    logic       pup_sel;
    logic [4:0] committed_code;

    always #4 clk = ~clk;

    atten_prog_seq #(.PUP_SEL(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_code(req_code), .req_direct(req_direct), .ctl_bits(ctl_bits),
        .le(le), .pup_sel(pup_sel), .committed_code(committed_code)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit started = 0;
    bit done = 0;

    typedef struct { logic [4:0] code; bit dir; } exp_t;
    exp_t sb[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic send(input logic [4:0] code, input bit dir);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_code = code; req_direct = dir;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        e.code = code; e.dir = dir;
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor / scoreboard
    logic [4:0] p_bits, p_comm;
    logic p_le, p_ready;
    int bits_age = 1000, fall_age = 1000, hi_age = 0, commit_age = 1000, busy_age = 0;
    bit pulse_seen = 0, any_commit = 0;

    always @(negedge clk) begin
        if (started) begin
            bit rose, fell, bchg, cev;
            exp_t f;
            rose = le && !p_le;
            fell = !le && p_le;
            bchg = (ctl_bits != p_bits);
            cev = 0;
            bits_age++; fall_age++; hi_age++; commit_age++; busy_age++;
            f.code = '0; f.dir = 0;
            if (sb.size() > 0) f = sb[0];
            if (rose) begin
                chk(bits_age >= SETUP_C, f.dir ? "R9 setup before rise" : "R4 setup before rise",
                    bits_age, SETUP_C);
                if (f.dir) begin
                    chk(committed_code == ctl_bits, "R9 commit at rise", committed_code, ctl_bits);
                    cev = 1;
                end else begin
                    chk(committed_code == p_comm, "R7 no commit at rise", committed_code, p_comm);
                    pulse_seen = 1;
                end
                hi_age = 0;
            end
            if (fell) begin
                if (pulse_seen) begin
                    chk(hi_age >= PULSE_C, "R5 pulse width", hi_age, PULSE_C);
                    chk(hi_age == PULSE_C, "R12 pulse count", hi_age, PULSE_C);
                    chk(committed_code == ctl_bits, "R7 commit at fall", committed_code, ctl_bits);
                    cev = 1;
                    pulse_seen = 0;
                end else begin
                    chk(!bchg, "R10 strobe drops first", ctl_bits, p_bits);
                end
                fall_age = 0;
            end
            if (bchg) begin
                if (!le && !p_le)
                    chk(fall_age >= HOLD_C, "R6 hold after fall", fall_age, HOLD_C);
                if (le && p_le) begin
                    chk(committed_code == ctl_bits, "R8 direct commit", committed_code, ctl_bits);
                    cev = 1;
                end
                bits_age = 0;
            end
            if (cev) begin
                if (any_commit)
                    chk(commit_age >= UPD_C, "R11 update spacing", commit_age, UPD_C);
                any_commit = 1;
                commit_age = 0;
            end
            if (!req_ready && p_ready) busy_age = 0;
            if (req_ready && !p_ready) begin
                chk(busy_age >= UPD_C, "R3 busy interval", busy_age, UPD_C);
                if (sb.size() == 0) begin
                    chk(0, "R1 unexpected completion", 0, 1);
                end else begin
                    f = sb.pop_front();
                    chk(committed_code == f.code, "R1 committed code", committed_code, f.code);
                    chk(ctl_bits == f.code, "R1 control word", ctl_bits, f.code);
                    chk(le == f.dir, f.dir ? "R8 strobe held high" : "R4 strobe parked low",
                        le, f.dir);
                end
            end
        end
        p_bits = ctl_bits; p_comm = committed_code; p_le = le; p_ready = req_ready;
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog expired", 0, 1);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(le == 1'b0, "R2 reset strobe low", le, 0);
        chk(ctl_bits == 5'd0, "R2 reset word", ctl_bits, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready after reset", req_ready, 1);
        chk(committed_code == 5'd16, "R2 power-up default", committed_code, 16);
        chk(pup_sel == 1'b1, "R2 select output", pup_sel, 1);
        started = 1;
        repeat (10) @(negedge clk);
        chk(le == 1'b0 && committed_code == 5'd16, "R2 default held", committed_code, 16);

        // latched: each weight, extremes
        send(5'd1, 0);  send(5'd2, 0);  send(5'd4, 0);  send(5'd8, 0);
        send(5'd16, 0); send(5'd31, 0); send(5'd0, 0);  send(5'd0, 0);
        // latched -> transparent, transparent updates
        send(5'd21, 1); send(5'd10, 1); send(5'd10, 1); send(5'd31, 1);
        // transparent -> latched
        send(5'd5, 0);
        // request waiting while busy must be ignored (R3)
        send(5'd7, 0);
        @(negedge clk);
        req_valid = 1'b1; req_code = 5'd24; req_direct = 1'b1;
        repeat (20) @(negedge clk);
        chk(req_ready == 1'b0, "R3 ready low while busy", req_ready, 0);
        chk(le == 1'b0, "R3 waiting request ignored (strobe)", le, 0);
        chk(ctl_bits == 5'd7, "R3 waiting request ignored (word)", ctl_bits, 7);
        req_valid = 1'b0;
        send(5'd24, 1);
        send(5'd24, 0);

        while (sb.size() != 0 || !req_ready) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(committed_code == 5'd24 && le == 1'b0, "R1 final state", committed_code, 24);
        done = 1;
        finish_run();
    end
endmodule